// File: doc/BRIEF.md
# Script Instruction Prefetch Queue

This block reads instruction dwords ahead of a script-processor core and hands them to the decoder in program order. It issues sequential read requests on a memory request/response port. It keeps up to eight dwords either queued or on their way back from memory. The decoder takes the dwords from a valid/ready output, and each dword comes with the address it was read from.

The queue goes stale whenever the instruction stream may have changed. These events flush it:
- a memory-to-memory move or a store, unless that instruction carries its no-flush marking;
- a write to the script pointer;
- a transfer-control instruction whose condition is true;
- a self-clearing flush bit in the control register.

A flush empties the queue and restarts fetching. The restart address is the new pointer for a pointer write, the branch target for a taken branch, and otherwise the address of the next dword not yet delivered. Every read request carries a generation tag, so responses that were issued before a flush are dropped when they return. A prefetch-enable input held low keeps the queue empty and stops all requests.

Output back-pressure: when `out_valid` is high and `out_ready` is low, the offered dword and its address stay unchanged. The one exception is a flush, which takes `out_valid` low. The memory side accepts a request only on a cycle where `mem_req_valid` and `mem_req_ready` are both high. Responses come back in request order, each with the tag of its request.

Top module: `insn_prefetch_queue`

## Requirements
- R1: A cycle with `ev_mmove` high and `ev_mmove_nf` low flushes the queue. `out_valid` is low in that cycle and in the next one. Fetching restarts at the address of the next undelivered dword. With `ev_mmove_nf` high the queue is left untouched.
- R2: A cycle with `ev_store` high and `ev_store_nf` low flushes the queue in the same way as R1. With `ev_store_nf` high the queue is left untouched.
- R3: `ev_ptr_wr` flushes the queue. The next request address, and the next delivered dword address, equal `ptr_wdata`. This address wins over a taken branch in the same cycle.
- R4: `ev_xfer` with `ev_xfer_taken` high flushes the queue and restarts at `xfer_target`. With `ev_xfer_taken` low the queue is left intact.
- R5: A control write with `ctl_wdata` bit 6 set makes `ctl_flush_bit` read 1 for exactly the next cycle. That cycle flushes the queue, and the bit then reads 0. A control write with bit 6 clear has no effect on the queue.
- R6: Queued dwords plus outstanding requests never exceed 8. With the output stalled, exactly 8 requests are issued after a flush, and then `mem_req_valid` stays low.
- R7: A response whose request was issued before the latest flush is never delivered.
- R8: In a cycle that flushes, `out_valid` is low even when `out_ready` is high. No pop takes place, so the restart address is the one held before that cycle.
- R9: While `pf_en` is low, `out_valid` and `mem_req_valid` are low. After `pf_en` rises again, delivery resumes at the next undelivered address.
- R10: Consecutive request addresses and consecutive delivered addresses step by 4 and wrap modulo 2^32.
- R11: Dwords are delivered in address order. `out_data` is the memory response for `out_addr`. A stalled output keeps its data stable.
- R12: After reset, `out_valid` is 0, `ctl_flush_bit` is 0, and the first request address is 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_en | input | 1 | Prefetch enable |
| ev_mmove | input | 1 | Memory-to-memory move executed |
| ev_mmove_nf | input | 1 | The move is the no-flush variant |
| ev_store | input | 1 | Store executed |
| ev_store_nf | input | 1 | The store has its no-flush option set |
| ev_ptr_wr | input | 1 | Script pointer written |
| ptr_wdata | input | 32 | New script pointer value |
| ev_xfer | input | 1 | Transfer-control instruction executed |
| ev_xfer_taken | input | 1 | Its condition is true |
| xfer_target | input | 32 | Branch target address |
| ctl_wr_en | input | 1 | Control register write |
| ctl_wdata | input | 8 | Control write data; bit 6 requests a flush |
| ctl_flush_bit | output | 1 | Readback of the self-clearing flush bit |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read address |
| mem_req_tag | output | 3 | Generation tag of the request |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_tag | input | 3 | Tag echoed with the response |
| mem_rsp_data | input | 32 | Response dword |
| out_valid | output | 1 | Dword available to the decoder |
| out_ready | input | 1 | Decoder takes the dword |
| out_data | output | 32 | Instruction dword |
| out_addr | output | 32 | Address of `out_data` |

## Verification
The checks assume the memory answers every accepted request exactly once, in order, at least one cycle after accepting it, and echoes its tag. They also assume fewer than eight flushes happen while an older response is still outstanding; otherwise the tag could alias. The bench memory model holds a fixed three-cycle pipeline and echoes tags unchanged. It can be frozen so that old responses sit in flight across a flush. Event pulses are always single-cycle and are driven on the falling clock edge.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  typedef logic [31:0] word_t;

  typedef struct packed {
    logic  hit;      // queue contents are stale this cycle
    word_t addr;     // where fetching resumes
  } flush_t;
endpackage

// File: rtl/ipq_flush_ctrl.sv
module ipq_flush_ctrl
  import ipq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_mmove,
  input  logic   ev_mmove_nf,
  input  logic   ev_store,
  input  logic   ev_store_nf,
  input  logic   ev_ptr_wr,
  input  word_t  ptr_wdata,
  input  logic   ev_xfer,
  input  logic   ev_xfer_taken,
  input  word_t  xfer_target,
  input  logic   ctl_wr_en,
  input  logic   ctl_flush_wbit,
  input  word_t  head_addr,
  output flush_t flush,
  output logic   sw_flush_q
);
  logic mm_hit, st_hit, br_hit;

  // Software flush bit: set by a write, clears itself one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_flush_q <= 1'b0;
    else        sw_flush_q <= ctl_wr_en & ctl_flush_wbit;
  end

  always_comb begin
    mm_hit    = ev_mmove & ~ev_mmove_nf;
    st_hit    = ev_store & ~ev_store_nf;
    br_hit    = ev_xfer & ev_xfer_taken;
    flush.hit = mm_hit | st_hit | br_hit | ev_ptr_wr | sw_flush_q;
    if (ev_ptr_wr)   flush.addr = ptr_wdata;
    else if (br_hit) flush.addr = xfer_target;
    else             flush.addr = head_addr;
  end
endmodule

// File: rtl/ipq_fifo.sv
module ipq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          nonempty
);
  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (level != '0);
  assign do_pop   = pop & nonempty;
  assign head     = store_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !clear) store_q[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)   wr_ptr <= step(wr_ptr);
      if (do_pop) rd_ptr <= step(rd_ptr);
      level <= level + CW'(push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ipq_fetch_ctrl.sv
module ipq_fetch_ctrl
  import ipq_pkg::*;
#(
  parameter int    DEPTH      = 8,
  parameter int    GEN_W      = 3,
  parameter word_t RESET_ADDR = 32'h100,
  localparam int   CW         = $clog2(DEPTH + 1),
  localparam int   SW         = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_en,
  input  logic             kill,
  input  word_t            restart_addr,
  input  logic [CW-1:0]    level,
  output logic             req_valid,
  input  logic             req_ready,
  output word_t            req_addr,
  output logic [GEN_W-1:0] req_tag,
  input  logic             rsp_valid,
  input  logic [GEN_W-1:0] rsp_tag,
  output logic             rsp_live,
  output logic [CW-1:0]    inflight
);
  localparam logic [SW-1:0] LIMIT = SW'(DEPTH);

  word_t            fetch_addr;
  logic [GEN_W-1:0] gen;
  logic             credit_ok, req_fire;

  // Outstanding requests of any generation hold a slot until they return.
  assign credit_ok = ({1'b0, level} + {1'b0, inflight}) < LIMIT;
  assign req_valid = pf_en & ~kill & credit_ok;
  assign req_fire  = req_valid & req_ready;
  assign req_addr  = fetch_addr;
  assign req_tag   = gen;
  assign rsp_live  = rsp_valid & (rsp_tag == gen) & pf_en & ~kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_addr <= RESET_ADDR;
      gen        <= '0;
      inflight   <= '0;
    end else begin
      inflight <= inflight + CW'(req_fire) - CW'(rsp_valid);
      if (kill) gen <= gen + 1'b1;
      if (kill || !pf_en) fetch_addr <= restart_addr;
      else if (req_fire)  fetch_addr <= fetch_addr + 32'd4;
    end
  end
endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue
  import ipq_pkg::*;
#(
  parameter int    DEPTH      = 8,
  parameter int    GEN_W      = 3,
  parameter int    CTL_W      = 8,
  parameter int    FLUSH_BIT  = 6,
  parameter word_t RESET_ADDR = 32'h100,
  localparam int   CW         = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_en,
  input  logic             ev_mmove,
  input  logic             ev_mmove_nf,
  input  logic             ev_store,
  input  logic             ev_store_nf,
  input  logic             ev_ptr_wr,
  input  logic [31:0]      ptr_wdata,
  input  logic             ev_xfer,
  input  logic             ev_xfer_taken,
  input  logic [31:0]      xfer_target,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             ctl_flush_bit,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  output logic [GEN_W-1:0] mem_req_tag,
  input  logic             mem_rsp_valid,
  input  logic [GEN_W-1:0] mem_rsp_tag,
  input  logic [31:0]      mem_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic [31:0]      out_addr
);
  flush_t        flush;
  word_t         head_addr;
  logic          pf_en_q, dis_edge, kill_any;
  logic          push, pop, nonempty;
  logic [CW-1:0] fifo_level, inflight_cnt;

  ipq_flush_ctrl u_flush (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_mmove      (ev_mmove),
    .ev_mmove_nf   (ev_mmove_nf),
    .ev_store      (ev_store),
    .ev_store_nf   (ev_store_nf),
    .ev_ptr_wr     (ev_ptr_wr),
    .ptr_wdata     (ptr_wdata),
    .ev_xfer       (ev_xfer),
    .ev_xfer_taken (ev_xfer_taken),
    .xfer_target   (xfer_target),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_flush_wbit(ctl_wdata[FLUSH_BIT]),
    .head_addr     (head_addr),
    .flush         (flush),
    .sw_flush_q    (ctl_flush_bit)
  );

  // Dropping enable also retires the current generation, so responses
  // issued before the disable cannot be queued after re-enable.
  assign dis_edge = pf_en_q & ~pf_en;
  assign kill_any = flush.hit | dis_edge;

  ipq_fetch_ctrl #(
    .DEPTH     (DEPTH),
    .GEN_W     (GEN_W),
    .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .pf_en       (pf_en),
    .kill        (kill_any),
    .restart_addr(flush.addr),
    .level       (fifo_level),
    .req_valid   (mem_req_valid),
    .req_ready   (mem_req_ready),
    .req_addr    (mem_req_addr),
    .req_tag     (mem_req_tag),
    .rsp_valid   (mem_rsp_valid),
    .rsp_tag     (mem_rsp_tag),
    .rsp_live    (push),
    .inflight    (inflight_cnt)
  );

  ipq_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (kill_any | ~pf_en),
    .push     (push),
    .push_data(mem_rsp_data),
    .pop      (pop),
    .head     (out_data),
    .level    (fifo_level),
    .nonempty (nonempty)
  );

  assign out_valid = nonempty & pf_en & ~kill_any;
  assign pop       = out_valid & out_ready;
  assign out_addr  = head_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_addr <= RESET_ADDR;
      pf_en_q   <= 1'b0;
    end else begin
      pf_en_q <= pf_en;
      if (flush.hit) head_addr <= flush.addr;
      else if (pop)  head_addr <= head_addr + 32'd4;
    end
  end
endmodule

// File: rtl/ipq_checker.sv
module ipq_checker #(
  parameter int  DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pf_en,
  input logic          kill_any,
  input logic          ev_mmove,
  input logic          ev_mmove_nf,
  input logic          ev_store,
  input logic          ev_store_nf,
  input logic          ev_ptr_wr,
  input logic [31:0]   ptr_wdata,
  input logic          ev_xfer,
  input logic          ev_xfer_taken,
  input logic [31:0]   xfer_target,
  input logic          ctl_flush_bit,
  input logic          ctl_wr_en,
  input logic [7:0]    ctl_wdata,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [31:0]   mem_req_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic [31:0]   out_addr,
  input logic [CW-1:0] fifo_level,
  input logic [CW-1:0] inflight_cnt
);
  AST_MMOVE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mmove && !ev_mmove_nf) |=> !out_valid); // R1
  AST_STORE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store && !ev_store_nf) |=> !out_valid); // R2
  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_wr |=> (mem_req_addr == $past(ptr_wdata))); // R3
  AST_BRANCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer && ev_xfer_taken && !ev_ptr_wr) |=> (mem_req_addr == $past(xfer_target))); // R4
  AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_flush_bit && !(ctl_wr_en && ctl_wdata[6])) |=> !ctl_flush_bit); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fifo_level} + {1'b0, inflight_cnt}) <= (CW+1)'(DEPTH)); // R6
  AST_FLUSH_BEATS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    kill_any |-> !out_valid); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_en |-> (!out_valid && !mem_req_valid)); // R9
  AST_REQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !kill_any) |=> (mem_req_addr == $past(mem_req_addr) + 32'd4)); // R10
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !kill_any) |=> (out_addr == $past(out_addr) + 32'd4)); // R11
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!out_valid || ($stable(out_data) && $stable(out_addr)))); // R11
endmodule

bind insn_prefetch_queue ipq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pf_en        (pf_en),
  .kill_any     (kill_any),
  .ev_mmove     (ev_mmove),
  .ev_mmove_nf  (ev_mmove_nf),
  .ev_store     (ev_store),
  .ev_store_nf  (ev_store_nf),
  .ev_ptr_wr    (ev_ptr_wr),
  .ptr_wdata    (ptr_wdata),
  .ev_xfer      (ev_xfer),
  .ev_xfer_taken(ev_xfer_taken),
  .xfer_target  (xfer_target),
  .ctl_flush_bit(ctl_flush_bit),
  .ctl_wr_en    (ctl_wr_en),
  .ctl_wdata    (ctl_wdata),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_addr     (out_addr),
  .fifo_level   (fifo_level),
  .inflight_cnt (inflight_cnt)
);

// File: tb/insn_prefetch_queue_test.sv
module insn_prefetch_queue_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_en = 1'b1;
  logic        ev_mmove = 0, ev_mmove_nf = 0, ev_store = 0, ev_store_nf = 0;
  logic        ev_ptr_wr = 0, ev_xfer = 0, ev_xfer_taken = 0;
  logic [31:0] ptr_wdata = '0, xfer_target = '0;
  logic        ctl_wr_en = 0;
  logic [7:0]  ctl_wdata = '0;
  logic        ctl_flush_bit;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic [2:0]  mem_req_tag;
  logic        mem_rsp_valid;
  logic [2:0]  mem_rsp_tag;
  logic [31:0] mem_rsp_data;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_data, out_addr;

  int          n_checks = 0, n_fails = 0, req_fires = 0;
  logic [31:0] exp_pc;
  logic        pause = 1'b0;

  always #2 clk = ~clk;

  insn_prefetch_queue uut (
    .clk(clk), .rst_n(rst_n), .pf_en(pf_en),
    .ev_mmove(ev_mmove), .ev_mmove_nf(ev_mmove_nf),
    .ev_store(ev_store), .ev_store_nf(ev_store_nf),
    .ev_ptr_wr(ev_ptr_wr), .ptr_wdata(ptr_wdata),
    .ev_xfer(ev_xfer), .ev_xfer_taken(ev_xfer_taken), .xfer_target(xfer_target),
    .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_flush_bit(ctl_flush_bit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr)
  );

  // Memory model: fixed in-order pipeline, data is the inverted address.
  logic        st_v [LAT];
  logic [31:0] st_a [LAT];
  logic [2:0]  st_t [LAT];

  assign mem_req_ready = ~pause;
  assign mem_rsp_valid = st_v[LAT-1] & ~pause;
  assign mem_rsp_data  = ~st_a[LAT-1];
  assign mem_rsp_tag   = st_t[LAT-1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        st_v[i] <= 1'b0; st_a[i] <= '0; st_t[i] <= '0;
      end
    end else if (!pause) begin
      st_v[0] <= mem_req_valid;
      st_a[0] <= mem_req_addr;
      st_t[0] <= mem_req_tag;
      for (int i = 1; i < LAT; i++) begin
        st_v[i] <= st_v[i-1]; st_a[i] <= st_a[i-1]; st_t[i] <= st_t[i-1];
      end
      if (mem_req_valid) req_fires <= req_fires + 1;
    end
  end

  task automatic check(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    ev_mmove = 0; ev_mmove_nf = 0; ev_store = 0; ev_store_nf = 0;
    ev_ptr_wr = 0; ev_xfer = 0; ev_xfer_taken = 0; ctl_wr_en = 0;
  endtask

  task automatic pop_one(input logic [31:0] exp, input string rq);
    int w = 0;
    @(negedge clk);
    while (!out_valid && w < 100) begin @(negedge clk); w++; end
    check(out_valid, rq, "out_valid", 32'(out_valid), 32'd1);
    check(out_addr == exp, rq, "out_addr", out_addr, exp);
    check(out_data == ~exp, rq, "out_data", out_data, ~exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    exp_pc = exp + 32'd4;
  endtask

  task automatic wait_full();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!out_valid, "R12", "out_valid after reset", 32'(out_valid), 0);
    check(!ctl_flush_bit, "R12", "flush bit after reset", 32'(ctl_flush_bit), 0);
    check(mem_req_addr == 32'h100, "R12", "first request", mem_req_addr, 32'h100);
    rst_n = 1'b1;
    exp_pc = 32'h100;
  endtask

  task automatic t_stream();
    for (int i = 0; i < 6; i++) pop_one(exp_pc, "R11");
  endtask

  task automatic t_fill();
    int snap;
    @(negedge clk);
    ev_ptr_wr = 1; ptr_wdata = 32'h1000; snap = req_fires;
    pulse_clear();
    wait_full();
    check(req_fires - snap == 8, "R6", "requests after flush", 32'(req_fires - snap), 8);
    check(!mem_req_valid, "R6", "request stalled when full", 32'(mem_req_valid), 0);
    check(out_addr == 32'h1000, "R3", "restart at pointer", out_addr, 32'h1000);
    @(negedge clk);
    check(out_data == ~32'h1000, "R11", "data held under stall", out_data, ~32'h1000);
    exp_pc = 32'h1000;
    pop_one(exp_pc, "R3");
    pop_one(exp_pc, "R6");
  endtask

  task automatic t_mmove();
    wait_full();
    ev_mmove = 1; ev_mmove_nf = 1; pulse_clear();
    check(out_valid, "R1", "no-flush move keeps queue", 32'(out_valid), 1);
    check(out_addr == exp_pc, "R1", "head kept", out_addr, exp_pc);
    ev_mmove = 1; pulse_clear();
    check(!out_valid, "R1", "move empties queue", 32'(out_valid), 0);
    pop_one(exp_pc, "R1");
  endtask

  task automatic t_store();
    wait_full();
    ev_store = 1; ev_store_nf = 1; pulse_clear();
    check(out_valid, "R2", "no-flush store keeps queue", 32'(out_valid), 1);
    ev_store = 1; pulse_clear();
    check(!out_valid, "R2", "store empties queue", 32'(out_valid), 0);
    pop_one(exp_pc, "R2");
  endtask

  task automatic t_branch();
    wait_full();
    ev_xfer = 1; ev_xfer_taken = 0; xfer_target = 32'h3000; pulse_clear();
    check(out_valid, "R4", "untaken branch keeps queue", 32'(out_valid), 1);
    pop_one(exp_pc, "R4");
    @(negedge clk);
    ev_xfer = 1; ev_xfer_taken = 1; pulse_clear();
    pop_one(32'h3000, "R4");
    @(negedge clk);
    ev_xfer = 1; ev_xfer_taken = 1; xfer_target = 32'h7000;
    ev_ptr_wr = 1; ptr_wdata = 32'h4000; pulse_clear();
    pop_one(32'h4000, "R3");
  endtask

  task automatic t_sw();
    wait_full();
    ctl_wr_en = 1; ctl_wdata = 8'hBF; pulse_clear();
    check(out_valid, "R5", "write without bit 6", 32'(out_valid), 1);
    check(!ctl_flush_bit, "R5", "bit stays clear", 32'(ctl_flush_bit), 0);
    ctl_wr_en = 1; ctl_wdata = 8'h40; pulse_clear();
    check(ctl_flush_bit, "R5", "bit set after write", 32'(ctl_flush_bit), 1);
    check(!out_valid, "R5", "flush in bit cycle", 32'(out_valid), 0);
    @(negedge clk);
    check(!ctl_flush_bit, "R5", "bit self-clears", 32'(ctl_flush_bit), 0);
    pop_one(exp_pc, "R5");
  endtask

  task automatic t_stale();
    @(negedge clk);
    ev_ptr_wr = 1; ptr_wdata = 32'h5000; pulse_clear();
    @(negedge clk);
    pause = 1'b1;
    @(negedge clk);
    ev_ptr_wr = 1; ptr_wdata = 32'h6000; pulse_clear();
    pause = 1'b0;
    pop_one(32'h6000, "R7");
    pop_one(exp_pc, "R7");
  endtask

  task automatic t_flushpop();
    wait_full();
    out_ready = 1'b1; ev_mmove = 1;
    #1;
    check(!out_valid, "R8", "valid during flush+pop", 32'(out_valid), 0);
    pulse_clear();
    out_ready = 1'b0;
    pop_one(exp_pc, "R8");
  endtask

  task automatic t_disable();
    int snap;
    wait_full();
    pf_en = 1'b0;
    @(negedge clk);
    snap = req_fires;
    check(!out_valid, "R9", "no output while disabled", 32'(out_valid), 0);
    check(!mem_req_valid, "R9", "no request while disabled", 32'(mem_req_valid), 0);
    repeat (10) @(negedge clk);
    check(req_fires == snap, "R9", "requests while disabled", 32'(req_fires), 32'(snap));
    pf_en = 1'b1;
    pop_one(exp_pc, "R9");
  endtask

  task automatic t_wrap();
    @(negedge clk);
    ev_ptr_wr = 1; ptr_wdata = 32'hFFFF_FFF8; pulse_clear();
    pop_one(32'hFFFF_FFF8, "R10");
    pop_one(32'hFFFF_FFFC, "R10");
    pop_one(32'h0000_0000, "R10");
    pop_one(32'h0000_0004, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_stream();
    t_fill();
    t_mmove();
    t_store();
    t_branch();
    t_sw();
    t_stale();
    t_flushpop();
    t_disable();
    t_wrap();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule